// File: doc/BRIEF.md
# Register Redirection Lookup

This block rewrites an instruction operand before the register file sees it. An operand carries a 5-bit architectural register number and a class bit that says whether it names an integer or a floating-point register. The block compares that pair against every slot of a 16-slot remap table at once. Each slot is a 16-bit word. When a slot matches, the operand is steered to a 7-bit physical index, so it can reach any of 128 registers. The same slot also says whether the operand is a vector and whether its element width is overridden.

When no slot matches, the operand passes through unchanged. It stays a scalar at its natural width. The table contents arrive as a packed input from a separate storage block, and the lookup itself is purely combinational. Decode logic feeds the block one operand at a time and uses the returned index, vector flag and element width to address the register file.

Top module: `redir_cam_lookup`

## Requirements
- R1: A slot word has this layout. Bit 15 is the vector flag. Bits 14..8 are the 7-bit physical index. Bit 7 is the class bit, where 1 means float and 0 means integer. Bits 6..5 are the width code. Bits 4..0 are the 5-bit key. Slot k occupies bits 16k+15..16k of `table_i`.
- R2: A slot matches only when its key equals `op_num_i` and its class bit equals `op_fp_i`. A slot whose key matches but whose class differs does not match.
- R3: A slot whose 16 bits are all zero is empty and never matches. This holds even for an integer operand 0.
- R4: On a miss, `hit_o` is 0, `phys_idx_o` is `op_num_i` zero-extended to 7 bits, `vec_o` is 0 and `wcode_o` is 00.
- R5: On a hit, `hit_o` is 1, and `phys_idx_o`, `vec_o` and `wcode_o` are copied from the matching slot.
- R6: When several slots match, the lowest-numbered slot supplies the outputs.
- R7: `elem_bits_o` reports the element width in bits. Code 00 gives XLEN for an integer operand and FLEN for a float operand. Code 01 gives 8, code 10 gives 16 and code 11 gives 32. A miss uses the code-00 width.
- R8: The outputs follow input changes with no clock edge in between.
- R9: Every physical index from 0 to 127 can be produced, including 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_num_i | input | 5 | Architectural register number of the operand |
| op_fp_i | input | 1 | Operand class: 1 = float, 0 = integer |
| table_i | input | 256 | Sixteen packed 16-bit remap slots, slot 0 in the low bits |
| hit_o | output | 1 | A slot matched |
| phys_idx_o | output | 7 | Physical register index |
| vec_o | output | 1 | Operand is a vector |
| wcode_o | output | 2 | Effective width-override code |
| elem_bits_o | output | 7 | Effective element width in bits |

## Verification
Class qualification and duplicate priority can act on the same lookup. To provoke this, the bench fills a lower slot with the right key but the wrong class, and places correct matches in two higher slots. The outputs are judged correct only if they come from the lowest slot whose key and class both agree. A second overlap places an empty slot in front of a real entry for integer operand 0. The real entry must win over the zero word, even though that word's key field also reads zero.

// File: rtl/redir_pkg.sv
`timescale 1ns/1ps
package redir_pkg;

    localparam int KEY_W   = 5;
    localparam int IDX_W   = 7;
    localparam int WCODE_W = 2;
    localparam int ENT_W   = 16;

    // Slot word layout (bit positions are fixed by the storage block)
    typedef struct packed {
        logic                vec;
        logic [IDX_W-1:0]    idx;
        logic                is_fp;
        logic [WCODE_W-1:0]  wcode;
        logic [KEY_W-1:0]    key;
    } redir_ent_t;

    typedef enum logic [WCODE_W-1:0] {
        WC_NATIVE = 2'b00,
        WC_B8     = 2'b01,
        WC_B16    = 2'b10,
        WC_B32    = 2'b11
    } wcode_e;

    typedef struct packed {
        logic                hit;
        logic [IDX_W-1:0]    idx;
        logic                vec;
        logic [WCODE_W-1:0]  wcode;
    } redir_res_t;

endpackage

// File: rtl/redir_slot_match.sv
`timescale 1ns/1ps
module redir_slot_match
    import redir_pkg::*;
(
    input  redir_ent_t          ent_i,
    input  logic [KEY_W-1:0]    op_num_i,
    input  logic                op_fp_i,
    output logic                match_o
);
    logic empty_d;
    logic key_eq_d;
    logic cls_eq_d;

    always_comb begin
        empty_d  = (ent_i == '0);
        key_eq_d = (ent_i.key == op_num_i);
        cls_eq_d = (ent_i.is_fp == op_fp_i);
        match_o  = key_eq_d && cls_eq_d && !empty_d;
    end
endmodule

// File: rtl/redir_prio_pick.sv
`timescale 1ns/1ps
module redir_prio_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    // before_d[i] is set when any request below i is present
    logic [N-1:0] before_d;

    assign before_d[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign before_d[g] = before_d[g-1] | req_i[g-1];
        end
        for (g = 0; g < N; g++) begin : g_grant
            assign grant_o[g] = req_i[g] & ~before_d[g];
        end
    endgenerate

    assign any_o = |req_i;
endmodule

// File: rtl/redir_width_decode.sv
`timescale 1ns/1ps
module redir_width_decode
    import redir_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int FLEN = 64,
    parameter int BW   = 7
) (
    input  logic [WCODE_W-1:0] wcode_i,
    input  logic               is_fp_i,
    output logic [BW-1:0]      bits_o
);
    always_comb begin
        unique case (wcode_e'(wcode_i))
            WC_B8:   bits_o = BW'(8);
            WC_B16:  bits_o = BW'(16);
            WC_B32:  bits_o = BW'(32);
            default: bits_o = is_fp_i ? BW'(FLEN) : BW'(XLEN);
        endcase
    end
endmodule

// File: rtl/redir_cam_lookup.sv
`timescale 1ns/1ps
module redir_cam_lookup
    import redir_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int XLEN    = 32,
    parameter int FLEN    = 64,
    localparam int MAXLEN = (XLEN > FLEN) ? XLEN : FLEN,
    localparam int BW     = $clog2(MAXLEN) + 1,
    localparam int TBL_W  = NUM_ENT * ENT_W
) (
    input  logic [KEY_W-1:0]   op_num_i,
    input  logic               op_fp_i,
    input  logic [TBL_W-1:0]   table_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   phys_idx_o,
    output logic               vec_o,
    output logic [WCODE_W-1:0] wcode_o,
    output logic [BW-1:0]      elem_bits_o
);
    redir_ent_t           ents_d [NUM_ENT];
    logic [NUM_ENT-1:0]   match_d;
    logic [NUM_ENT-1:0]   grant_d;
    logic                 any_d;
    redir_ent_t           sel_d;
    redir_res_t           res_d;

    genvar g;
    generate
        for (g = 0; g < NUM_ENT; g++) begin : g_slot
            assign ents_d[g] = redir_ent_t'(table_i[g*ENT_W +: ENT_W]);
            redir_slot_match u_match (
                .ent_i    (ents_d[g]),
                .op_num_i (op_num_i),
                .op_fp_i  (op_fp_i),
                .match_o  (match_d[g])
            );
        end
    endgenerate

    redir_prio_pick #(.N(NUM_ENT)) u_pick (
        .req_i   (match_d),
        .grant_o (grant_d),
        .any_o   (any_d)
    );

    // One-hot AND-OR mux of the winning slot
    always_comb begin
        sel_d = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            sel_d = sel_d | (ents_d[i] & {ENT_W{grant_d[i]}});
        end
    end

    always_comb begin
        res_d.hit = any_d;
        if (any_d) begin
            res_d.idx   = sel_d.idx;
            res_d.vec   = sel_d.vec;
            res_d.wcode = sel_d.wcode;
        end else begin
            res_d.idx   = {{(IDX_W-KEY_W){1'b0}}, op_num_i};
            res_d.vec   = 1'b0;
            res_d.wcode = WC_NATIVE;
        end
    end

    redir_width_decode #(.XLEN(XLEN), .FLEN(FLEN), .BW(BW)) u_width (
        .wcode_i (res_d.wcode),
        .is_fp_i (op_fp_i),
        .bits_o  (elem_bits_o)
    );

    assign hit_o      = res_d.hit;
    assign phys_idx_o = res_d.idx;
    assign vec_o      = res_d.vec;
    assign wcode_o    = res_d.wcode;
endmodule

// File: rtl/redir_cam_lookup_chk.sv
`timescale 1ns/1ps
module redir_cam_lookup_chk
    import redir_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int XLEN    = 32,
    parameter int FLEN    = 64,
    parameter int BW      = 7
) (
    input logic [KEY_W-1:0]         op_num_i,
    input logic                     op_fp_i,
    input logic [NUM_ENT*ENT_W-1:0] table_i,
    input logic                     hit_o,
    input logic [IDX_W-1:0]         phys_idx_o,
    input logic                     vec_o,
    input logic [WCODE_W-1:0]       wcode_o,
    input logic [BW-1:0]            elem_bits_o
);
    logic       some_ok;
    redir_ent_t e;

    always_comb begin
        some_ok = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            e = redir_ent_t'(table_i[i*ENT_W +: ENT_W]);
            if (e != '0 && e.key == op_num_i && e.is_fp == op_fp_i &&
                e.idx == phys_idx_o && e.vec == vec_o && e.wcode == wcode_o)
                some_ok = 1'b1;
        end
    end

    always_comb begin
        // R4
        miss_pass_chk: assert (hit_o || (phys_idx_o == IDX_W'(op_num_i) && !vec_o && wcode_o == 2'b00))
            else $error("miss did not pass operand through");
        // R5
        hit_src_chk: assert (!hit_o || some_ok)
            else $error("hit outputs match no qualifying slot");
        // R7
        w8_chk: assert (wcode_o != 2'b01 || elem_bits_o == BW'(8))
            else $error("code 01 width wrong");
        // R7
        w16_chk: assert (wcode_o != 2'b10 || elem_bits_o == BW'(16))
            else $error("code 10 width wrong");
        // R7
        w32_chk: assert (wcode_o != 2'b11 || elem_bits_o == BW'(32))
            else $error("code 11 width wrong");
        // R7
        native_chk: assert (wcode_o != 2'b00 || elem_bits_o == (op_fp_i ? BW'(FLEN) : BW'(XLEN)))
            else $error("native width wrong");
    end
endmodule

bind redir_cam_lookup redir_cam_lookup_chk #(
    .NUM_ENT(NUM_ENT), .XLEN(XLEN), .FLEN(FLEN), .BW(BW)
) u_chk (
    .op_num_i    (op_num_i),
    .op_fp_i     (op_fp_i),
    .table_i     (table_i),
    .hit_o       (hit_o),
    .phys_idx_o  (phys_idx_o),
    .vec_o       (vec_o),
    .wcode_o     (wcode_o),
    .elem_bits_o (elem_bits_o)
);

// File: tb/redir_cam_lookup_tb.sv
`timescale 1ns/1ps
module redir_cam_lookup_tb;
    localparam int N    = 16;
    localparam int XL   = 32;
    localparam int FL   = 64;
    localparam int BW   = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      op_num;
    logic            op_fp;
    logic [N*16-1:0] tbl;
    logic            hit;
    logic [6:0]      pidx;
    logic            vec;
    logic [1:0]      wcode;
    logic [BW-1:0]   ebits;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    redir_cam_lookup #(.NUM_ENT(N), .XLEN(XL), .FLEN(FL)) u_dut (
        .op_num_i    (op_num),
        .op_fp_i     (op_fp),
        .table_i     (tbl),
        .hit_o       (hit),
        .phys_idx_o  (pidx),
        .vec_o       (vec),
        .wcode_o     (wcode),
        .elem_bits_o (ebits)
    );

    function automatic logic [15:0] mk(input bit v, input int idx, input bit fp,
                                       input int w, input int key);
        return {v, 7'(idx), fp, 2'(w), 5'(key)};
    endfunction

    task automatic put(input int slot, input logic [15:0] w);
        tbl[slot*16 +: 16] = w;
    endtask

    task automatic clear_tbl();
        tbl = '0;
    endtask

    // Expected outputs derived from the requirements
    task automatic check(input string req, input int op, input bit fp);
        bit          eh = 1'b0;
        logic [6:0]  ei = 7'(op);
        bit          ev = 1'b0;
        logic [1:0]  ew = 2'b00;
        logic [BW-1:0] eb;
        for (int j = 0; j < N; j++) begin
            logic [15:0] s = tbl[j*16 +: 16];
            if (!eh && s != 16'h0 && s[4:0] == 5'(op) && s[7] == fp) begin
                eh = 1'b1; ei = s[14:8]; ev = s[15]; ew = s[6:5];
            end
        end
        case (ew)
            2'b01:   eb = BW'(8);
            2'b10:   eb = BW'(16);
            2'b11:   eb = BW'(32);
            default: eb = fp ? BW'(FL) : BW'(XL);
        endcase
        n_chk++;
        if (hit !== eh || pidx !== ei || vec !== ev || wcode !== ew || ebits !== eb) begin
            n_bad++;
            $display("FAIL %s op=%0d fp=%0d: got hit=%0d idx=%0d vec=%0d w=%0d bits=%0d exp hit=%0d idx=%0d vec=%0d w=%0d bits=%0d",
                     req, op, fp, hit, pidx, vec, wcode, ebits, eh, ei, ev, ew, eb);
        end
    endtask

    task automatic apply(input string req, input int op, input bit fp);
        @(negedge clk);
        op_num = 5'(op);
        op_fp  = fp;
        #1;
        check(req, op, fp);
    endtask

    task automatic t_reset_empty();
        clear_tbl();
        apply("R3", 0, 1'b0);
        apply("R4", 17, 1'b0);
        apply("R4", 31, 1'b1);
    endtask

    task automatic t_basic_hit();
        clear_tbl();
        put(4, mk(1, 90, 0, 0, 6));
        put(9, mk(0, 45, 1, 2, 12));
        apply("R1", 6, 1'b0);
        apply("R5", 12, 1'b1);
        apply("R4", 7, 1'b0);
    endtask

    task automatic t_class();
        clear_tbl();
        put(0, mk(1, 100, 0, 1, 3));
        apply("R2", 3, 1'b1);
        apply("R2", 3, 1'b0);
    endtask

    task automatic t_dup_class_mix();
        clear_tbl();
        put(1, mk(1, 11, 0, 3, 20));
        put(5, mk(0, 55, 1, 1, 20));
        put(8, mk(1, 88, 1, 2, 20));
        apply("R6", 20, 1'b1);
        apply("R6", 20, 1'b0);
        put(1, 16'h0);
        put(2, mk(0, 22, 0, 0, 0));
        put(3, mk(1, 33, 0, 1, 0));
        apply("R3", 0, 1'b0);
    endtask

    task automatic t_widths();
        clear_tbl();
        for (int w = 0; w < 4; w++) begin
            put(w, mk(0, 60 + w, 0, w, w + 1));
            put(w + 4, mk(1, 70 + w, 1, w, w + 1));
        end
        for (int w = 0; w < 4; w++) begin
            apply("R7", w + 1, 1'b0);
            apply("R7", w + 1, 1'b1);
        end
        apply("R7", 25, 1'b1);
    endtask

    task automatic t_index_range();
        clear_tbl();
        put(15, mk(1, 127, 1, 3, 31));
        put(14, mk(0, 0, 0, 0, 30));
        apply("R9", 31, 1'b1);
        apply("R9", 30, 1'b0);
    endtask

    task automatic t_comb_follow();
        clear_tbl();
        put(2, mk(0, 77, 0, 2, 9));
        @(negedge clk);
        op_num = 5'd9; op_fp = 1'b0;
        #0.5;
        check("R8", 9, 1'b0);
        op_num = 5'd10;
        #0.5;
        check("R8", 10, 1'b0);
        put(6, mk(1, 99, 0, 1, 10));
        #0.5;
        check("R8", 10, 1'b0);
    endtask

    initial begin
        op_num = '0;
        op_fp  = 1'b0;
        tbl    = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_empty();
        t_basic_hit();
        t_class();
        t_dup_class_mix();
        t_widths();
        t_index_range();
        t_comb_follow();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule